// File: doc/BRIEF.md
# Translation Context and Mode Selector

This block sits in front of a two-stage address translator. For each memory access it looks at the access kind, the 64-bit effective address and the current privilege and relocation state. It then decides which of four outcomes applies. A real-mode access gets its physical address formed directly. An access that needs translation gets a partition/process context and the set of translation stages to run. An access to an address quadrant that the current mode may not use produces a segment fault. An unknown access code is rejected.

The two most significant address bits select a quadrant. Together with the hypervisor bit, the quadrant picks the partition and process identifiers that the later table walk uses. Each classification is registered and offered on an output with a valid/ready handshake. A new request is accepted only when the output slot is empty or is being drained in the same cycle. The table walk itself lives elsewhere.

Top module: `xlate_ctx_sel`

## Requirements
- R1: Access codes are 0 read, 1 write, 2 fetch. Relocation is on for a fetch when `irelo` is 1, and for a read or write when `drelo` is 1. Result kinds are 0 real, 1 translate, 2 segment fault, 3 bad type.
- R2: When relocation is off and either `hv_mode` is 1 or `hv_present` is 0, the kind is real. `phys_addr` is then the effective address with bits 63:60 cleared, ORed with `rmo_reg` only when address bit 63 is 0.
- R3: With `hv_mode` 1 and relocation on, the quadrant (address bits 63:62) maps to a (partition, process) context as follows: 0 gives (0, `proc_reg`), 1 gives (`part_reg`, `proc_reg`), 2 gives (`part_reg`, 0) and 3 gives (0, 0).
- R4: With `hv_mode` 0 and the access not in real mode, quadrant 0 gives (`part_reg`, `proc_reg`) and quadrant 3 gives (`part_reg`, 0).
- R5: With `hv_mode` 0 and the access not in real mode, quadrants 1 and 2 give kind segment fault. A read or write sets `dseg_fault` and puts the effective address on `fault_addr`. A fetch sets only `iseg_fault`, and `fault_addr` stays 0.
- R6: For a translate result, `need_proc` equals the relocation state. `need_part` is 1 when the selected partition is nonzero or `hv_mode` is 0.
- R7: For a translate result with relocation off, `guest_raddr` is the effective address with bits 63:62 cleared. With relocation on it is 0.
- R8: Access code 3 gives kind bad type, whatever the other inputs are.
- R9: `req_ready` equals not `out_valid` or `out_ready`. A request accepted at an edge appears on the outputs after that edge. All outputs hold steady while `out_valid` is 1 and `out_ready` is 0.
- R10: After reset `out_valid` is 0.
- R11: Every output field that does not belong to the result kind is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| acc_type | input | 2 | Access code: 0 read, 1 write, 2 fetch, 3 invalid |
| eff_addr | input | 64 | Effective address |
| hv_mode | input | 1 | Hypervisor privilege bit |
| irelo | input | 1 | Instruction relocation enable |
| drelo | input | 1 | Data relocation enable |
| hv_present | input | 1 | A hypervisor level exists |
| part_reg | input | 12 | Partition identifier register |
| proc_reg | input | 20 | Process identifier register |
| rmo_reg | input | 64 | Real-mode offset register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 real, 1 translate, 2 segment fault, 3 bad type |
| phys_addr | output | 64 | Real-mode physical address |
| ctx_part | output | 12 | Selected partition |
| ctx_proc | output | 20 | Selected process |
| need_proc | output | 1 | Process-scoped stage required |
| need_part | output | 1 | Partition-scoped stage required |
| guest_raddr | output | 64 | Guest real address when the process stage is skipped |
| iseg_fault | output | 1 | Instruction segment fault |
| dseg_fault | output | 1 | Data segment fault |
| fault_addr | output | 64 | Captured faulting data address |

## Verification
The bench mixes seeded random requests with directed cases aimed at the places where this block is easy to get wrong. A real-mode address with bit 63 set must not pick up the offset; a design that ORs it in unconditionally would return the wrong physical address. In hypervisor mode, quadrant 1 with a zero partition register must report no partition stage; a design that keys that stage off the quadrant alone would schedule a needless walk. A guest fetch to quadrant 1 or 2 must flag only the instruction fault and leave the fault address at zero; a design that shares the data path would set the wrong flag or leak the address. The bench also holds `out_ready` low for several cycles to catch outputs that change, or a `req_ready` that stays high, while a result waits.

// File: rtl/xctx_pkg.sv
package xctx_pkg;
    localparam int AW         = 64;
    localparam int PART_W     = 12;
    localparam int PROC_W     = 20;
    localparam int QUAD_W     = 2;
    localparam int RM_CLR_W   = 4;
    localparam int EA_VALID_W = AW - QUAD_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_REAL    = 2'd0,
        RES_XLATE   = 2'd1,
        RES_SEGF    = 2'd2,
        RES_BADTYPE = 2'd3
    } res_e;

    typedef struct packed {
        res_e              kind;
        logic [AW-1:0]     phys;
        logic [PART_W-1:0] part;
        logic [PROC_W-1:0] proc;
        logic              need_proc;
        logic              need_part;
        logic [AW-1:0]     graddr;
        logic              iseg;
        logic              dseg;
        logic [AW-1:0]     faddr;
    } res_t;
endpackage

// File: rtl/xctx_reloc.sv
module xctx_reloc
    import xctx_pkg::*;
(
    input  logic [1:0] acc_type,
    input  logic       irelo,
    input  logic       drelo,
    output logic       reloc_on,
    output logic       is_fetch,
    output logic       bad_type
);
    always_comb begin
        is_fetch = (acc_e'(acc_type) == ACC_FETCH);
        bad_type = (acc_e'(acc_type) == ACC_RSVD);
        reloc_on = is_fetch ? irelo : drelo;
    end
endmodule

// File: rtl/xctx_quad.sv
module xctx_quad
    import xctx_pkg::*;
(
    input  logic [QUAD_W-1:0] quad,
    input  logic              hv_mode,
    input  logic [PART_W-1:0] part_reg,
    input  logic [PROC_W-1:0] proc_reg,
    output logic              legal,
    output logic [PART_W-1:0] sel_part,
    output logic [PROC_W-1:0] sel_proc
);
    always_comb begin
        legal    = 1'b1;
        sel_part = '0;
        sel_proc = '0;
        if (hv_mode) begin
            unique case (quad)
                2'd0: sel_proc = proc_reg;
                2'd1: begin
                    sel_part = part_reg;
                    sel_proc = proc_reg;
                end
                2'd2: sel_part = part_reg;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin
                    sel_part = part_reg;
                    sel_proc = proc_reg;
                end
                2'd3: sel_part = part_reg;
                default: legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/xctx_realmode.sv
module xctx_realmode
    import xctx_pkg::*;
(
    input  logic [AW-1:0] eff_addr,
    input  logic [AW-1:0] rmo_reg,
    output logic [AW-1:0] real_pa
);
    logic [AW-1:0] trimmed;

    always_comb begin
        trimmed = {{RM_CLR_W{1'b0}}, eff_addr[AW-RM_CLR_W-1:0]};
        real_pa = eff_addr[AW-1] ? trimmed : (trimmed | rmo_reg);
    end
endmodule

// File: rtl/xlate_ctx_sel.sv
module xlate_ctx_sel
    import xctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        acc_type,
    input  logic [AW-1:0]     eff_addr,
    input  logic              hv_mode,
    input  logic              irelo,
    input  logic              drelo,
    input  logic              hv_present,
    input  logic [PART_W-1:0] part_reg,
    input  logic [PROC_W-1:0] proc_reg,
    input  logic [AW-1:0]     rmo_reg,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        res_kind,
    output logic [AW-1:0]     phys_addr,
    output logic [PART_W-1:0] ctx_part,
    output logic [PROC_W-1:0] ctx_proc,
    output logic              need_proc,
    output logic              need_part,
    output logic [AW-1:0]     guest_raddr,
    output logic              iseg_fault,
    output logic              dseg_fault,
    output logic [AW-1:0]     fault_addr
);
    typedef struct packed {
        logic valid;
        res_t res;
    } state_t;

    state_t st_d, st_q;
    res_t   nxt;

    logic              reloc_on, is_fetch, bad_type;
    logic              q_legal;
    logic [PART_W-1:0] q_part;
    logic [PROC_W-1:0] q_proc;
    logic [AW-1:0]     real_pa;

    xctx_reloc u_reloc (
        .acc_type (acc_type),
        .irelo    (irelo),
        .drelo    (drelo),
        .reloc_on (reloc_on),
        .is_fetch (is_fetch),
        .bad_type (bad_type)
    );

    xctx_quad u_quad (
        .quad     (eff_addr[AW-1 -: QUAD_W]),
        .hv_mode  (hv_mode),
        .part_reg (part_reg),
        .proc_reg (proc_reg),
        .legal    (q_legal),
        .sel_part (q_part),
        .sel_proc (q_proc)
    );

    xctx_realmode u_rm (
        .eff_addr (eff_addr),
        .rmo_reg  (rmo_reg),
        .real_pa  (real_pa)
    );

    assign req_ready = !st_q.valid || out_ready;

    always_comb begin
        nxt = '0;
        if (bad_type) begin
            nxt.kind = RES_BADTYPE;
        end else if (!reloc_on && (hv_mode || !hv_present)) begin
            nxt.kind = RES_REAL;
            nxt.phys = real_pa;
        end else if (!q_legal) begin
            nxt.kind = RES_SEGF;
            if (is_fetch) begin
                nxt.iseg = 1'b1;
            end else begin
                nxt.dseg  = 1'b1;
                nxt.faddr = eff_addr;
            end
        end else begin
            nxt.kind      = RES_XLATE;
            nxt.part      = q_part;
            nxt.proc      = q_proc;
            nxt.need_proc = reloc_on;
            nxt.need_part = (q_part != '0) || !hv_mode;
            nxt.graddr    = reloc_on ? '0 : {{QUAD_W{1'b0}}, eff_addr[EA_VALID_W-1:0]};
        end

        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (req_valid && req_ready) begin
            st_d.valid = 1'b1;
            st_d.res   = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign res_kind    = st_q.res.kind;
    assign phys_addr   = st_q.res.phys;
    assign ctx_part    = st_q.res.part;
    assign ctx_proc    = st_q.res.proc;
    assign need_proc   = st_q.res.need_proc;
    assign need_part   = st_q.res.need_part;
    assign guest_raddr = st_q.res.graddr;
    assign iseg_fault  = st_q.res.iseg;
    assign dseg_fault  = st_q.res.dseg;
    assign fault_addr  = st_q.res.faddr;
endmodule

// File: rtl/xctx_sel_chk.sv
module xctx_sel_chk
    import xctx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        res_kind,
    input logic [AW-1:0]     phys_addr,
    input logic [PART_W-1:0] ctx_part,
    input logic [PROC_W-1:0] ctx_proc,
    input logic              need_proc,
    input logic              need_part,
    input logic              iseg_fault,
    input logic              dseg_fault,
    input logic [AW-1:0]     fault_addr
);
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(res_kind) && $stable(phys_addr)
            && $stable(ctx_part) && $stable(ctx_proc) && $stable(fault_addr)); // R9

    AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid); // R9

    AST_ONE_SEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({iseg_fault, dseg_fault})); // R5

    AST_SEGF_NO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && res_kind == 2'd2 |-> !need_proc && !need_part
            && (iseg_fault || dseg_fault)); // R11

    AST_XLATE_HAS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && res_kind == 2'd1 && !need_proc |-> need_part); // R6

    AST_FETCH_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && iseg_fault |-> fault_addr == '0); // R5
endmodule

bind xlate_ctx_sel xctx_sel_chk u_chk (.*);

// File: tb/xlate_ctx_sel_tb.sv
module xlate_ctx_sel_tb;
    import xctx_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        acc_type = '0;
    logic [AW-1:0]     eff_addr = '0;
    logic              hv_mode = 1'b0, irelo = 1'b0, drelo = 1'b0, hv_present = 1'b1;
    logic [PART_W-1:0] part_reg = '0;
    logic [PROC_W-1:0] proc_reg = '0;
    logic [AW-1:0]     rmo_reg = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [1:0]        res_kind;
    logic [AW-1:0]     phys_addr, guest_raddr, fault_addr;
    logic [PART_W-1:0] ctx_part;
    logic [PROC_W-1:0] ctx_proc;
    logic              need_proc, need_part, iseg_fault, dseg_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xlate_ctx_sel u_dut (.*);

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic res_t model(input logic [1:0] t, input logic [AW-1:0] ea, input logic hv,
                                   input logic ir, input logic dr, input logic hp,
                                   input logic [PART_W-1:0] pr, input logic [PROC_W-1:0] pc,
                                   input logic [AW-1:0] rmo);
        res_t r;
        logic rel;
        logic [1:0] q;
        r   = '0;
        rel = (t == 2'd2) ? ir : dr;
        q   = ea[63:62];
        if (t == 2'd3) begin
            r.kind = RES_BADTYPE;
        end else if (!rel && (hv || !hp)) begin
            r.kind = RES_REAL;
            r.phys = (ea & 64'h0FFF_FFFF_FFFF_FFFF) | (ea[63] ? 64'd0 : rmo);
        end else if (!hv && (q == 2'd1 || q == 2'd2)) begin
            r.kind = RES_SEGF;
            if (t == 2'd2) r.iseg = 1'b1;
            else begin
                r.dseg  = 1'b1;
                r.faddr = ea;
            end
        end else begin
            r.kind = RES_XLATE;
            if (hv) begin
                r.part = (q == 2'd1 || q == 2'd2) ? pr : '0;
                r.proc = (q == 2'd0 || q == 2'd1) ? pc : '0;
            end else begin
                r.part = pr;
                r.proc = (q == 2'd0) ? pc : '0;
            end
            r.need_proc = rel;
            r.need_part = (r.part != '0) || !hv;
            r.graddr    = rel ? 64'd0 : (ea & 64'h3FFF_FFFF_FFFF_FFFF);
        end
        return r;
    endfunction

    task automatic run_one(input logic [1:0] t, input logic [AW-1:0] ea, input logic hv,
                           input logic ir, input logic dr, input logic hp,
                           input logic [PART_W-1:0] pr, input logic [PROC_W-1:0] pc,
                           input logic [AW-1:0] rmo, input int stall);
        res_t e;
        string ctag;
        e = model(t, ea, hv, ir, dr, hp, pr, pc, rmo);
        ctag = hv ? "R3" : "R4";
        @(negedge clk);
        acc_type = t; eff_addr = ea; hv_mode = hv; irelo = ir; drelo = dr;
        hv_present = hp; part_reg = pr; proc_reg = pc; rmo_reg = rmo;
        req_valid = 1'b1;
        out_ready = (stall == 0);
        chk("R9 ready before accept", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int s = 0; s <= stall; s++) begin
            if (s > 0) @(negedge clk);
            chk("R9 out_valid", {63'd0, out_valid}, 64'd1);
            chk((t == 2'd3) ? "R8 kind" : "R1 kind", {62'd0, res_kind}, {62'd0, e.kind});
            chk((e.kind == RES_REAL) ? "R2 phys" : "R11 phys", phys_addr, e.phys);
            chk({ctag, " part"}, {52'd0, ctx_part}, {52'd0, e.part});
            chk({ctag, " proc"}, {44'd0, ctx_proc}, {44'd0, e.proc});
            chk("R6 stages", {62'd0, need_proc, need_part}, {62'd0, e.need_proc, e.need_part});
            chk("R7 guest_raddr", guest_raddr, e.graddr);
            chk("R5 seg flags", {62'd0, iseg_fault, dseg_fault}, {62'd0, e.iseg, e.dseg});
            chk("R5 fault_addr", fault_addr, e.faddr);
            if (stall > 0) chk("R9 ready while stalled", {63'd0, req_ready}, 64'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R9 drained", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", {63'd0, out_valid}, 64'd0);

        // R2: real mode, bit 63 set keeps offset out; bit 63 clear ORs it in
        run_one(2'd0, 64'hF234_5678_9ABC_DEF0, 1'b1, 1'b0, 1'b0, 1'b1, 12'h5, 20'h7,
                64'h0000_0001_0000_0000, 0);
        run_one(2'd1, 64'h7234_5678_9ABC_DEF0, 1'b1, 1'b0, 1'b0, 1'b1, 12'h5, 20'h7,
                64'h3000_0001_0000_0000, 1);
        // R1: fetch uses irelo, data uses drelo
        run_one(2'd2, 64'h0000_0000_0000_1000, 1'b1, 1'b1, 1'b0, 1'b1, 12'h5, 20'h7, 64'd0, 0);
        run_one(2'd0, 64'h0000_0000_0000_1000, 1'b1, 1'b1, 1'b0, 1'b1, 12'h5, 20'h7, 64'd0, 0);
        // R3/R6: hypervisor quadrant 1 with zero partition needs no partition stage
        run_one(2'd0, 64'h4000_0000_0000_2000, 1'b1, 1'b0, 1'b1, 1'b1, 12'h0, 20'h9, 64'd0, 0);
        run_one(2'd1, 64'h8000_0000_0000_2000, 1'b1, 1'b0, 1'b1, 1'b1, 12'h3, 20'h9, 64'd0, 2);
        // R5: guest illegal quadrants, fetch vs data
        run_one(2'd2, 64'h4000_0000_DEAD_0000, 1'b0, 1'b1, 1'b1, 1'b1, 12'h3, 20'h9, 64'd0, 0);
        run_one(2'd1, 64'h8000_0000_BEEF_0000, 1'b0, 1'b1, 1'b1, 1'b1, 12'h3, 20'h9, 64'd0, 3);
        // R7/R4: guest relocation off, quadrant 3
        run_one(2'd0, 64'hC000_0000_0000_4000, 1'b0, 1'b1, 1'b0, 1'b1, 12'h3, 20'h9, 64'd0, 0);
        // R8: invalid access code
        run_one(2'd3, 64'h4000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 1'b1, 12'h3, 20'h9, 64'hFF, 0);
        // R2: no hypervisor level present, guest bit clear still real mode
        run_one(2'd0, 64'h1234_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 12'h3, 20'h9, 64'h10, 0);

        for (int i = 0; i < 1500; i++) begin
            logic [1:0] t;
            t = ($urandom_range(0, 7) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            run_one(t, {$urandom(), $urandom()}, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                    ($urandom_range(0, 3) != 0),
                    ($urandom_range(0, 3) == 0) ? 12'd0 : 12'($urandom()),
                    20'($urandom()), {$urandom(), $urandom()}, $urandom_range(0, 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule